// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external serial master read and write a small bank of byte-wide registers over a framed four-signal serial link. The signals are an active-low select, a serial clock, a data input and a push-pull data output. Each frame opens with a command byte that gives the direction and the first register. The bytes after it go into, or come out of, consecutive registers, and the register pointer wraps to zero past the last register. The data output comes with a drive-enable, so a board can join data-in and data-out into one shared wire.

The link signals are resynchronised into the system clock. Rising serial-clock edges sample input bits. Falling edges move the output. The register bank also has a parallel write port and a registered read port for the surrounding core logic. A byte from the link is committed only once all eight of its bits have arrived.

Top module: `spi_regif`

## Requirements
- R1: While the select input is high the frame logic is held idle: the bit count and byte phase clear, so the first byte after select falls is always decoded as a command, even when the previous frame ended mid-byte.
- R2: Command byte layout: bit 7 is the direction (1 = read, 0 = write), bits 6:5 must equal 2'b01 and bits 4:0 hold the start register. With any other value in bits 6:5 the frame changes no register and the output drive-enable stays low.
- R3: In a write frame each data byte, received MSB first and sampled on rising serial-clock edges, is stored in the current register, and the pointer then advances by one.
- R4: In a read frame the current register is shifted out MSB first. The first byte is loaded on the falling edge that ends the command byte, each later byte on the falling edge after the previous byte's last bit, and the output changes only after falling serial-clock edges.
- R5: After the last valid register (parameter, default 27) the pointer returns to register 0, for both reads and writes.
- R6: A command start register above the last valid register starts the frame at register 0.
- R7: A data byte that is cut short by select rising is discarded and changes no register.
- R8: The output drive-enable is high only during the data phase of a valid read frame, and low during the command byte and while select is high. This allows data-in and data-out to share one wire.
- R9: The core-side write port stores a byte into a register. The core-side read port returns the addressed register one clock after the address is applied.
- R10: After reset every register reads zero and the data output and drive-enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block, push-pull |
| spi_miso_oe | output | 1 | High while the block drives the data output |
| core_we | input | 1 | Core write strobe |
| core_waddr | input | 5 | Core write register index |
| core_wdata | input | 8 | Core write data |
| core_raddr | input | 5 | Core read register index |
| core_rdata | output | 8 | Registered core read data |

## Verification
The bench builds the block with its default parameters: 27 as the last register and two synchroniser stages. With those values the 5-bit command field can name registers 28 to 31, so the out-of-range start case is reachable, and a two-byte burst starting at register 27 crosses the wrap point. The serial clock runs eight system clocks per half period, which leaves room for the synchroniser latency before each bit is sampled. A shared-wire mode in the bench feeds the block's own output back into its data input during the read data phase.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int CMD_AW = 5;
  localparam logic [1:0] SUBADDR_OK = 2'b01;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;

  typedef struct packed {
    logic                  rd;
    logic [1:0]            sub;
    logic [CMD_AW-1:0]     addr;
  } cmd_t;
endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_regif_bank.sv
module spi_regif_bank #(
  parameter int LAST_REG = 27,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_we,
  input  logic [AW-1:0] spi_waddr,
  input  logic [7:0]    spi_wdata,
  input  logic [AW-1:0] spi_raddr,
  output logic [7:0]    spi_rdata,
  input  logic          core_we,
  input  logic [AW-1:0] core_waddr,
  input  logic [7:0]    core_wdata,
  input  logic [AW-1:0] core_raddr,
  output logic [7:0]    core_rdata
);
  localparam int DEPTH = LAST_REG + 1;
  localparam logic [AW-1:0] LAST_A = AW'(LAST_REG);

  logic [7:0] mem [DEPTH];

  // link writes take priority over core writes in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (spi_we && spi_waddr <= LAST_A) begin
      mem[spi_waddr] <= spi_wdata;
    end else if (core_we && core_waddr <= LAST_A) begin
      mem[core_waddr] <= core_wdata;
    end
  end

  always_comb begin
    spi_rdata = '0;
    if (spi_raddr <= LAST_A) spi_rdata = mem[spi_raddr];
  end

  always_ff @(posedge clk) begin
    if (rst)                      core_rdata <= '0;
    else if (core_raddr <= LAST_A) core_rdata <= mem[core_raddr];
    else                          core_rdata <= '0;
  end
endmodule

// File: rtl/spi_regif_ctrl.sv
module spi_regif_ctrl
  import spi_regif_pkg::*;
#(
  parameter int LAST_REG = 27
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              mosi_s,
  output logic              we,
  output logic [CMD_AW-1:0] waddr,
  output logic [7:0]        wdata,
  output logic [CMD_AW-1:0] raddr,
  input  logic [7:0]        rdata,
  output logic              miso,
  output logic              miso_oe,
  output logic              sck_fall,
  output logic              cmd_phase
);
  localparam logic [CMD_AW-1:0] LAST_A = CMD_AW'(LAST_REG);

  logic       sck_q;
  logic       sck_rise;
  logic [2:0] bit_cnt;
  logic [7:0] shift_in;
  logic [7:0] byte_in;
  logic [7:0] tx_sh;
  phase_e     phase;
  logic       is_rd;
  logic       cmd_ok;
  logic       load_pend;
  logic [CMD_AW-1:0] ptr;
  cmd_t       cmd;

  function automatic logic [CMD_AW-1:0] nxt(input logic [CMD_AW-1:0] a);
    return (a == LAST_A) ? '0 : a + 1'b1;
  endfunction

  assign sck_rise  = sck_s & ~sck_q;
  assign sck_fall  = ~sck_s & sck_q;
  assign byte_in   = {shift_in[6:0], mosi_s};
  assign cmd       = cmd_t'(byte_in);
  assign raddr     = ptr;
  assign miso      = tx_sh[7];
  assign cmd_phase = (phase == PH_CMD);

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      bit_cnt   <= '0;
      shift_in  <= '0;
      phase     <= PH_CMD;
      is_rd     <= 1'b0;
      cmd_ok    <= 1'b0;
      load_pend <= 1'b0;
      ptr       <= '0;
      tx_sh     <= '0;
      miso_oe   <= 1'b0;
      we        <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
    end else begin
      we <= 1'b0;
      if (sck_rise) begin
        shift_in <= byte_in;
        bit_cnt  <= bit_cnt + 1'b1;
        if (bit_cnt == 3'd7) begin
          if (phase == PH_CMD) begin
            phase     <= PH_DATA;
            is_rd     <= cmd.rd;
            cmd_ok    <= (cmd.sub == SUBADDR_OK);
            ptr       <= (cmd.addr > LAST_A) ? '0 : cmd.addr;
            load_pend <= cmd.rd && (cmd.sub == SUBADDR_OK);
          end else if (is_rd) begin
            load_pend <= cmd_ok;
          end else if (cmd_ok) begin
            we    <= 1'b1;
            waddr <= ptr;
            wdata <= byte_in;
            ptr   <= nxt(ptr);
          end
        end
      end
      if (sck_fall) begin
        if (load_pend) begin
          tx_sh     <= rdata;
          ptr       <= nxt(ptr);
          load_pend <= 1'b0;
          miso_oe   <= 1'b1;
        end else begin
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int LAST_REG = 27,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              core_we,
  input  logic [CMD_AW-1:0] core_waddr,
  input  logic [7:0]        core_wdata,
  input  logic [CMD_AW-1:0] core_raddr,
  output logic [7:0]        core_rdata
);
  logic              cs_n_s, sck_s, mosi_s;
  logic              spi_we;
  logic [CMD_AW-1:0] spi_waddr, spi_raddr;
  logic [7:0]        spi_wdata, spi_rdata;
  logic              sck_fall, cmd_phase;

  spi_regif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_cs_n, spi_sck, spi_mosi}),
    .q   ({cs_n_s, sck_s, mosi_s})
  );

  spi_regif_ctrl #(.LAST_REG(LAST_REG)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (cs_n_s),
    .sck_s     (sck_s),
    .mosi_s    (mosi_s),
    .we        (spi_we),
    .waddr     (spi_waddr),
    .wdata     (spi_wdata),
    .raddr     (spi_raddr),
    .rdata     (spi_rdata),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe),
    .sck_fall  (sck_fall),
    .cmd_phase (cmd_phase)
  );

  spi_regif_bank #(.LAST_REG(LAST_REG), .AW(CMD_AW)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .spi_we     (spi_we),
    .spi_waddr  (spi_waddr),
    .spi_wdata  (spi_wdata),
    .spi_raddr  (spi_raddr),
    .spi_rdata  (spi_rdata),
    .core_we    (core_we),
    .core_waddr (core_waddr),
    .core_wdata (core_wdata),
    .core_raddr (core_raddr),
    .core_rdata (core_rdata)
  );
endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk #(
  parameter int LAST_REG = 27
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n_s,
  input logic       sck_fall,
  input logic       cmd_phase,
  input logic       spi_we,
  input logic [4:0] spi_waddr,
  input logic       spi_miso,
  input logic       spi_miso_oe
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !spi_miso_oe); // R8
  AST_DRIVE_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
    spi_miso_oe |-> !cmd_phase); // R8
  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_miso) |-> ($past(sck_fall) || $past(cs_n_s))); // R4
  AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    spi_we |-> (spi_waddr <= 5'(LAST_REG))); // R5
  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    spi_we |=> !spi_we); // R3
  AST_COMMIT_FRAMED: assert property (@(posedge clk) disable iff (rst)
    spi_we |-> $past(!cs_n_s)); // R7
endmodule

bind spi_regif spi_regif_chk #(.LAST_REG(LAST_REG)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n_s      (cs_n_s),
  .sck_fall    (sck_fall),
  .cmd_phase   (cmd_phase),
  .spi_we      (spi_we),
  .spi_waddr   (spi_waddr),
  .spi_miso    (spi_miso),
  .spi_miso_oe (spi_miso_oe)
);

// File: tb/spi_regif_test.sv
module spi_regif_test;
  localparam time H = 40ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_cs_n = 1'b1;
  logic       spi_sck = 1'b0;
  logic       m_mosi = 1'b0;
  logic       m_drive = 1'b1;
  logic       sw_mode = 1'b0;
  logic       spi_mosi;
  logic       spi_miso, spi_miso_oe;
  logic       core_we = 1'b0;
  logic [4:0] core_waddr = '0, core_raddr = '0;
  logic [7:0] core_wdata = '0, core_rdata;
  int         n_tests = 0, n_fail = 0;

  always #2.5ns clk = ~clk;

  // shared-wire model: block output feeds its own input when master releases
  assign spi_mosi = (sw_mode && !m_drive) ? (spi_miso_oe ? spi_miso : 1'b0) : m_mosi;

  spi_regif uut (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .core_we(core_we), .core_waddr(core_waddr), .core_wdata(core_wdata),
    .core_raddr(core_raddr), .core_rdata(core_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spi_begin();
    @(negedge clk);
    spi_cs_n = 1'b0;
    #H;
  endtask

  task automatic spi_end();
    #H;
    spi_cs_n = 1'b1;
    m_drive  = 1'b1;
    #(4*H);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits,
                          output logic [7:0] rx, output logic [7:0] oe);
    rx = '0; oe = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      m_mosi = tx[i];
      #H;
      rx[i] = spi_miso;
      oe[i] = spi_miso_oe;
      spi_sck = 1'b1;
      #H;
      spi_sck = 1'b0;
    end
  endtask

  task automatic core_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    core_raddr = a;
    @(negedge clk);
    d = core_rdata;
  endtask

  task automatic spi_write(input logic [7:0] cmd, input logic [7:0] d0,
                           input logic [7:0] d1, input int n);
    logic [7:0] rx, oe;
    spi_begin();
    spi_bits(cmd, 8, rx, oe);
    if (n > 0) spi_bits(d0, 8, rx, oe);
    if (n > 1) spi_bits(d1, 8, rx, oe);
    spi_end();
  endtask

  task automatic test_reset();
    logic [7:0] d;
    check("R10 miso", {7'd0, spi_miso}, 8'h00);
    check("R10 oe", {7'd0, spi_miso_oe}, 8'h00);
    for (int a = 0; a <= 27; a++) begin
      core_read(5'(a), d);
      check("R10 reg", d, 8'h00);
    end
  endtask

  task automatic test_write_burst();
    logic [7:0] d;
    spi_write(8'h23, 8'hA1, 8'hB2, 2);
    spi_write(8'h25, 8'hC3, 8'h00, 1);
    core_read(5'd3, d); check("R3 reg3", d, 8'hA1);
    core_read(5'd4, d); check("R3 reg4", d, 8'hB2);
    core_read(5'd5, d); check("R3 reg5", d, 8'hC3);
  endtask

  task automatic test_read_burst();
    logic [7:0] rx, oe;
    spi_begin();
    spi_bits(8'hA3, 8, rx, oe);
    check("R8 oe low in command", oe, 8'h00);
    spi_bits(8'h00, 8, rx, oe); check("R4 byte0", rx, 8'hA1);
    check("R8 oe high in data", oe, 8'hFF);
    spi_bits(8'h00, 8, rx, oe); check("R4 byte1", rx, 8'hB2);
    spi_bits(8'h00, 8, rx, oe); check("R4 byte2", rx, 8'hC3);
    spi_end();
    check("R8 oe low idle", {7'd0, spi_miso_oe}, 8'h00);
  endtask

  task automatic test_wrap();
    logic [7:0] d, rx, oe;
    spi_write(8'h3B, 8'h11, 8'h22, 2);
    core_read(5'd27, d); check("R5 reg27", d, 8'h11);
    core_read(5'd0, d);  check("R5 reg0", d, 8'h22);
    spi_begin();
    spi_bits(8'hBB, 8, rx, oe);
    spi_bits(8'h00, 8, rx, oe); check("R5 read reg27", rx, 8'h11);
    spi_bits(8'h00, 8, rx, oe); check("R5 read wrap reg0", rx, 8'h22);
    spi_end();
  endtask

  task automatic test_out_of_range();
    logic [7:0] d;
    spi_write(8'h3E, 8'h5A, 8'h00, 1);
    core_read(5'd0, d); check("R6 start at reg0", d, 8'h5A);
  endtask

  task automatic test_bad_subaddr();
    logic [7:0] d, rx, oe;
    spi_write(8'h43, 8'hFF, 8'hFF, 2);
    core_read(5'd3, d); check("R2 reg3 unchanged", d, 8'hA1);
    core_read(5'd4, d); check("R2 reg4 unchanged", d, 8'hB2);
    spi_begin();
    spi_bits(8'hC3, 8, rx, oe);
    spi_bits(8'h00, 8, rx, oe);
    check("R2 no drive", oe, 8'h00);
    check("R2 no data", rx, 8'h00);
    spi_end();
  endtask

  task automatic test_partial();
    logic [7:0] d, rx, oe;
    spi_begin();
    spi_bits(8'h24, 8, rx, oe);
    spi_bits(8'hEE, 4, rx, oe);
    spi_end();
    core_read(5'd4, d); check("R7 partial byte dropped", d, 8'hB2);
    spi_begin();
    spi_bits(8'h20, 3, rx, oe);
    spi_end();
    spi_begin();
    spi_bits(8'hA4, 8, rx, oe);
    spi_bits(8'h00, 8, rx, oe); check("R1 fresh command after cut", rx, 8'hB2);
    spi_end();
  endtask

  task automatic test_core_port();
    logic [7:0] d, rx, oe;
    @(negedge clk);
    core_we = 1'b1; core_waddr = 5'd10; core_wdata = 8'h77;
    @(negedge clk);
    core_we = 1'b0;
    core_read(5'd10, d); check("R9 core read", d, 8'h77);
    spi_begin();
    spi_bits(8'hAA, 8, rx, oe);
    spi_bits(8'h00, 8, rx, oe); check("R9 link sees core write", rx, 8'h77);
    spi_end();
  endtask

  task automatic test_single_wire();
    logic [7:0] rx, oe;
    sw_mode = 1'b1;
    spi_begin();
    spi_bits(8'hA3, 8, rx, oe);
    m_drive = 1'b0;
    spi_bits(8'h00, 8, rx, oe); check("R8 shared wire byte0", rx, 8'hA1);
    spi_bits(8'h00, 8, rx, oe); check("R8 shared wire byte1", rx, 8'hB2);
    spi_end();
    sw_mode = 1'b0;
  endtask

  initial begin
    #(1ms);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (10) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    test_reset();
    test_write_burst();
    test_read_burst();
    test_wrap();
    test_out_of_range();
    test_bad_subaddr();
    test_partial();
    test_core_port();
    test_single_wire();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule